// File: doc/BRIEF.md
# Scratchpad Register File with Increment/Decrement Path

This block holds a bank of general-purpose registers, each made of two byte-wide halves that are written and read separately. A register number picks one entry. Either half of that entry can be copied into a holding register that feeds an increment/decrement unit. The unit's result can be written back, so the block can step a pointer up or down by one in place.

The same entry can also be loaded from an 8-bit data bus, or driven onto that bus and written back unchanged. A two-bit path mode chooses which of these happens in a cycle. A separate byte-wide address register captures either half of the selected entry and holds it until it is loaded again.

All state changes on the rising clock edge. The register contents are a plain memory with no reset, so a synthesis tool can map them to distributed RAM.

Top module: `rf_scratchpad`

## Requirements
- R1: While `rst` is high at a clock edge, `addr_out`, `bus_out` and the holding register are cleared to zero. The register contents are not cleared.
- R2: In path mode 2'b10, `bus_in` is written into the low half (bits 7:0) of the selected register when `wr_lo` is high, and into the high half (bits 15:8) when `wr_hi` is high. A half whose enable is low keeps its contents.
- R3: In path mode 2'b11, `bus_out` takes the low half of the selected register if `wr_lo` is high, and the high half otherwise. The register contents stay unchanged. In every other path mode, `bus_out` holds its value.
- R4: In path mode 2'b00, no register is written, whatever the write enables are.
- R5: At a clock edge, `rd_lo` loads bits 7:0 of the holding register from the selected register, and `rd_hi` loads bits 15:8. A half whose enable is low keeps its value.
- R6: The increment/decrement result is computed from the holding register without a clock:
  - with `cin` = 0, the result equals the holding value;
  - with `cin` = 1 and `dec` = 0, the result is the holding value plus 1, modulo 65536;
  - with `cin` = 1 and `dec` = 1, the result is the holding value minus 1, modulo 65536.
  
  `cout` is 1 only when an increment wraps from 16'hFFFF or a decrement wraps from 16'h0000.
- R7: In path mode 2'b01, the increment/decrement result is written into the halves of the selected register whose write enables are high. The other half keeps its contents.
- R8: At a clock edge, `addr_out` loads bits 15:8 of the selected register when `addr_hi_en` is high. Otherwise it loads bits 7:0 when `addr_lo_en` is high. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 4 | Number of the selected register |
| path_mode | input | 2 | 00 idle, 01 write back the inc/dec result, 10 load from the bus, 11 drive the bus and write back |
| wr_hi | input | 1 | Write enable, high half |
| wr_lo | input | 1 | Write enable, low half; in mode 11 it also picks the half driven onto the bus |
| rd_hi | input | 1 | Load the high half of the holding register |
| rd_lo | input | 1 | Load the low half of the holding register |
| dec | input | 1 | Decrement instead of increment |
| cin | input | 1 | Step amount (0 or 1) |
| addr_hi_en | input | 1 | Load the address register from the high half |
| addr_lo_en | input | 1 | Load the address register from the low half |
| bus_in | input | 8 | Data bus value to be written |
| addr_out | output | 8 | Address register |
| bus_out | output | 8 | Data bus value driven by the block |
| cout | output | 1 | Wrap indication from the increment/decrement unit |

## Verification
The bench builds the block with its default parameters: sixteen registers made of two 8-bit halves. This puts register 0 and register 15 within reach, so the selection is tested at both ends of its range. The full 16-bit step path is also covered, including the carry out of the low byte into the high byte and both wrap points of the inc/dec unit. Loading the holding register one half at a time, from two different registers, shows that each half is loaded on its own.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    PATH_IDLE    = 2'b00,
    PATH_INCDEC  = 2'b01,
    PATH_BUS_IN  = 2'b10,
    PATH_BUS_OUT = 2'b11
  } path_mode_e;
endpackage

// File: rtl/rf_bank.sv
// One byte-wide slice of the register array: synchronous write,
// asynchronous read, no reset, so it maps to distributed RAM.
module rf_bank #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[sel] <= wdata;
  end

  assign rdata = mem[sel];
endmodule

// File: rtl/rf_incdec.sv
// Adds or subtracts a one-bit step; the extra top bit flags a wrap.
module rf_incdec #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] din,
  input  logic             dec,
  input  logic             cin,
  output logic [WIDTH-1:0] dout,
  output logic             cout
);
  logic [WIDTH:0] ext;
  logic [WIDTH:0] step;

  assign step = {{WIDTH{1'b0}}, cin};

  always_comb begin
    if (dec) ext = {1'b0, din} - step;
    else     ext = {1'b0, din} + step;
  end

  assign dout = ext[WIDTH-1:0];
  assign cout = ext[WIDTH];
endmodule

// File: rtl/rf_scratchpad.sv
module rf_scratchpad #(
  parameter int REG_COUNT = 16,
  parameter int HALF_W    = 8,
  localparam int SEL_W    = $clog2(REG_COUNT),
  localparam int WORD_W   = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel,
  input  logic [1:0]        path_mode,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic              dec,
  input  logic              cin,
  input  logic              addr_hi_en,
  input  logic              addr_lo_en,
  input  logic [HALF_W-1:0] bus_in,
  output logic [HALF_W-1:0] addr_out,
  output logic [HALF_W-1:0] bus_out,
  output logic              cout
);
  import rf_pkg::*;

  path_mode_e          mode;
  logic [WORD_W-1:0]   rd_word;
  logic [WORD_W-1:0]   hold_q;
  logic [WORD_W-1:0]   step_word;
  logic [1:0]          half_we;
  logic [HALF_W-1:0]   addr_q;
  logic [HALF_W-1:0]   bus_q;

  assign mode    = path_mode_e'(path_mode);
  assign half_we = {wr_hi, wr_lo};

  // Index 0 is the low half, index 1 the high half.
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] wr_d;
    logic              we_h;

    always_comb begin
      case (mode)
        PATH_INCDEC: wr_d = step_word[h*HALF_W +: HALF_W];
        PATH_BUS_IN: wr_d = bus_in;
        default:     wr_d = rd_word[h*HALF_W +: HALF_W];
      endcase
    end

    assign we_h = half_we[h] && (mode != PATH_IDLE);

    rf_bank #(.DEPTH(REG_COUNT), .WIDTH(HALF_W)) u_bank (
      .clk   (clk),
      .we    (we_h),
      .sel   (sel),
      .wdata (wr_d),
      .rdata (rd_word[h*HALF_W +: HALF_W])
    );
  end

  rf_incdec #(.WIDTH(WORD_W)) u_incdec (
    .din  (hold_q),
    .dec  (dec),
    .cin  (cin),
    .dout (step_word),
    .cout (cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      addr_q <= '0;
      bus_q  <= '0;
    end else begin
      if (rd_lo) hold_q[HALF_W-1:0]      <= rd_word[HALF_W-1:0];
      if (rd_hi) hold_q[WORD_W-1:HALF_W] <= rd_word[WORD_W-1:HALF_W];
      if (addr_hi_en)      addr_q <= rd_word[WORD_W-1:HALF_W];
      else if (addr_lo_en) addr_q <= rd_word[HALF_W-1:0];
      if (mode == PATH_BUS_OUT)
        bus_q <= wr_lo ? rd_word[HALF_W-1:0] : rd_word[WORD_W-1:HALF_W];
    end
  end

  assign addr_out = addr_q;
  assign bus_out  = bus_q;
endmodule

// File: rtl/rf_scratchpad_chk.sv
module rf_scratchpad_chk #(
  parameter int HALF_W = 8,
  localparam int WORD_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        path_mode,
  input logic              addr_hi_en,
  input logic              addr_lo_en,
  input logic              dec,
  input logic              cin,
  input logic [WORD_W-1:0] hold_q,
  input logic [HALF_W-1:0] addr_out,
  input logic [HALF_W-1:0] bus_out,
  input logic              cout
);
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!addr_hi_en && !addr_lo_en) |=> $stable(addr_out));

  assert_bus_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (path_mode != 2'b11) |=> $stable(bus_out));

  assert_no_step_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    !cin |-> !cout);

  assert_inc_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (cin && !dec && cout) |-> (hold_q == {WORD_W{1'b1}}));

  assert_dec_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (cin && dec && cout) |-> (hold_q == '0));
endmodule

bind rf_scratchpad rf_scratchpad_chk #(.HALF_W(HALF_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .path_mode  (path_mode),
  .addr_hi_en (addr_hi_en),
  .addr_lo_en (addr_lo_en),
  .dec        (dec),
  .cin        (cin),
  .hold_q     (hold_q),
  .addr_out   (addr_out),
  .bus_out    (bus_out),
  .cout       (cout)
);

// File: tb/test_rf_scratchpad.sv
module test_rf_scratchpad;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] sel = '0;
  logic [1:0] path_mode = '0;
  logic       wr_hi = 0, wr_lo = 0, rd_hi = 0, rd_lo = 0;
  logic       dec = 0, cin = 0, addr_hi_en = 0, addr_lo_en = 0;
  logic [7:0] bus_in = '0;
  logic [7:0] addr_out, bus_out;
  logic       cout;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rf_scratchpad i_rf_scratchpad (
    .clk(clk), .rst(rst), .sel(sel), .path_mode(path_mode),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .dec(dec), .cin(cin), .addr_hi_en(addr_hi_en), .addr_lo_en(addr_lo_en),
    .bus_in(bus_in), .addr_out(addr_out), .bus_out(bus_out), .cout(cout)
  );

  // Each entry is {op, register, byte}.
  // op 0: bus write low, 1: bus write high, 2: read low, 3: read high,
  // 4: address from low half, 5: address from high half.
  localparam logic [15:0] VEC [13] = '{
    16'h00A5, 16'h103C, 16'h0F01, 16'h1FFE,
    16'h20A5, 16'h303C, 16'h2F01, 16'h3FFE,
    16'h4F01, 16'h503C, 16'h1077, 16'h20A5, 16'h3077
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_ctl();
    path_mode = 2'b00; wr_hi = 0; wr_lo = 0; rd_hi = 0; rd_lo = 0;
    addr_hi_en = 0; addr_lo_en = 0; cin = 0; dec = 0;
  endtask

  task automatic bus_write(input logic [3:0] r, input bit hi, input logic [7:0] v);
    sel = r; path_mode = 2'b10; wr_hi = hi; wr_lo = !hi; bus_in = v;
    step(); clear_ctl();
  endtask

  task automatic bus_read(input logic [3:0] r, input bit hi, output logic [7:0] v);
    sel = r; path_mode = 2'b11; wr_lo = !hi; wr_hi = hi;
    step(); v = bus_out; clear_ctl();
  endtask

  task automatic read_word(input logic [3:0] r, output logic [15:0] w);
    logic [7:0] lo, hi;
    bus_read(r, 0, lo);
    bus_read(r, 1, hi);
    w = {hi, lo};
  endtask

  task automatic load_hold(input logic [3:0] r, input bit lo_en, input bit hi_en);
    sel = r; rd_lo = lo_en; rd_hi = hi_en;
    step(); clear_ctl();
  endtask

  task automatic step_write(input logic [3:0] r, input bit d, input bit c,
                            input bit lo_en, input bit hi_en);
    sel = r; path_mode = 2'b01; dec = d; cin = c; wr_lo = lo_en; wr_hi = hi_en;
    step(); clear_ctl();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    repeat (3) step();
    rst = 0;
    step();
    // R1: outputs and holding register are zero after reset
    check("R1 addr_out", addr_out, 8'h00);
    check("R1 bus_out", bus_out, 8'h00);
    cin = 1; dec = 0; #1;
    check("R1 hold zero, inc no wrap", cout, 1'b0);
    dec = 1; #1;
    check("R1 hold zero, dec wraps", cout, 1'b1);
    clear_ctl();

    for (int i = 0; i < 13; i++) begin
      logic [3:0] op;
      logic [3:0] r;
      logic [7:0] v;
      op = VEC[i][15:12]; r = VEC[i][11:8]; v = VEC[i][7:0];
      case (op)
        4'd0: bus_write(r, 0, v);
        4'd1: bus_write(r, 1, v);
        4'd2: begin bus_read(r, 0, b); check("R2_R3 low readback", b, v); end
        4'd3: begin bus_read(r, 1, b); check("R2_R3 high readback", b, v); end
        4'd4: begin sel = r; addr_lo_en = 1; step(); clear_ctl();
                    check("R8 address low", addr_out, v); end
        default: begin sel = r; addr_hi_en = 1; step(); clear_ctl();
                    check("R8 address high", addr_out, v); end
      endcase
    end

    // R3: bus_out holds in modes other than 11
    bus_write(4'd9, 0, 8'h11);
    step_write(4'd9, 0, 0, 0, 0);
    check("R3 bus hold", bus_out, 8'h77);

    // R4: idle mode writes nothing
    sel = 4'd0; path_mode = 2'b00; wr_lo = 1; wr_hi = 1; bus_in = 8'hEE;
    step(); clear_ctl();
    read_word(4'd0, w);
    check("R4 idle no write", w, 16'h77A5);

    // R6/R7: increment with carry across the byte boundary
    bus_write(4'd3, 0, 8'hFF); bus_write(4'd3, 1, 8'h12);
    load_hold(4'd3, 1, 1);
    cin = 1; #1;
    check("R6 no wrap", cout, 1'b0);
    clear_ctl();
    step_write(4'd3, 0, 1, 1, 1);
    read_word(4'd3, w);
    check("R6_R7 increment", w, 16'h1300);

    // R6: increment wrap
    bus_write(4'd4, 0, 8'hFF); bus_write(4'd4, 1, 8'hFF);
    load_hold(4'd4, 1, 1);
    cin = 1; dec = 0; #1;
    check("R6 increment wrap cout", cout, 1'b1);
    clear_ctl();
    step_write(4'd4, 0, 1, 1, 1);
    read_word(4'd4, w);
    check("R6 increment wrap value", w, 16'h0000);

    // R6: decrement wrap
    load_hold(4'd4, 1, 1);
    cin = 1; dec = 1; #1;
    check("R6 decrement wrap cout", cout, 1'b1);
    clear_ctl();
    step_write(4'd4, 1, 1, 1, 1);
    read_word(4'd4, w);
    check("R6 decrement wrap value", w, 16'hFFFF);

    // R6: cin 0 passes the value to another register
    load_hold(4'd3, 1, 1);
    step_write(4'd5, 0, 0, 1, 1);
    read_word(4'd5, w);
    check("R6 pass through", w, 16'h1300);

    // R5: half loads of the holding register
    load_hold(4'd4, 1, 0);
    step_write(4'd6, 0, 0, 1, 1);
    read_word(4'd6, w);
    check("R5 half load", w, 16'h13FF);

    // R7: only the enabled half is written
    step_write(4'd0, 0, 1, 1, 0);
    read_word(4'd0, w);
    check("R7 low half only", w, 16'h7700);

    // R8: high enable has priority, then hold
    sel = 4'd3; addr_hi_en = 1; addr_lo_en = 1; step(); clear_ctl();
    check("R8 priority", addr_out, 8'h13);
    sel = 4'd4; step();
    check("R8 hold", addr_out, 8'h13);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule